// File: doc/BRIEF.md
# Packet FIFO pair with threshold-driven ready flags

This block sits between a host bus and the byte streams of a network MAC. Each direction has its own FIFO. The host loads outgoing bytes into the transmit FIFO, and the MAC drains them. The MAC fills the receive FIFO, and the host drains it. Every stored byte carries a packet-end tag. Both FIFOs show their head word without a read strobe, so the word is visible before it is consumed.

The host decides when to move data by watching two flags.

- **`txrdy`** tells the host there is room for a burst of writes.
- **`rxrdy`** tells the host there is something worth reading. That can be:
  - enough bytes,
  - a whole packet,
  - optionally, the header of the packet still arriving,
  - the notice that a packet was thrown away.

A transmit error reported by the MAC blocks `txrdy` until the host reads the error status. A receive packet that ends badly, or that did not fit in the FIFO, has its unread bytes removed. That event is then reported through `rxfail`.

Top module: `pkt_fifo_flags`

## Requirements
- R1: After reset the following hold.
  - Both FIFOs are empty: `mac_tx_valid` = 0 and `rx_valid` = 0.
  - `txrdy` = 1.
  - `rxrdy` = 0, `rxfail` = 0 and `tx_stat_err` = 0.
  - The transmit and receive thresholds are DEPTH/2.
  - The header length is 14 and header mode is off.
- R2: `txrdy` is 1 exactly when free transmit space (DEPTH minus stored words) is at least the transmit threshold and no transmit error is pending.
- R3: A `mac_tx_err` pulse sets the transmit error, which holds `txrdy` low. The error stays set until a cycle with `tx_stat_rd`:
  - In that cycle, `tx_stat_err` still reads 1.
  - From the next cycle on, it reads 0.
  - If a new error arrives in the same cycle as the read, the error stays set.
- R4: Each FIFO returns its words in write order, each with its packet-end tag. The head word is shown on the data outputs while the valid output is 1.
- R5: `rxrdy` is 1 whenever the receive FIFO holds at least the receive threshold number of bytes.
- R6: `rxrdy` is 1 whenever at least one complete, good packet (packet end written) is still in the receive FIFO, even below the threshold.
- R7: With header mode on, `rxrdy` is 1 once the packet in progress has stored at least the header-length number of bytes. With header mode off, this condition has no effect.
- R8: A receive packet is discarded, and the bytes of that packet the host has not yet read are removed, in either of two cases:
  - a receive write arrives with `mac_rx_bad` = 1 (that byte is not stored);
  - a packet-end write arrives for a packet that lost a byte to a full FIFO, or that finds the FIFO full.

  Earlier packets are kept. After a discard, `rxfail` and `rxrdy` are 1 until the cycle after an `rx_stat_rd`.
- R9: Writes into a full FIFO store nothing. Reads from an empty FIFO change nothing.
- R10: A `cfg_we` cycle writes the register selected by `cfg_addr`:
  - 0 = transmit threshold,
  - 1 = receive threshold,
  - 2 = header length,
  - 3 = header mode enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | AW+1 | Configuration write value |
| tx_wr | input | 1 | Host write into transmit FIFO |
| tx_wdata | input | DW | Host transmit byte |
| tx_weop | input | 1 | Host marks byte as packet end |
| txrdy | output | 1 | Transmit space at or above threshold and no error |
| mac_tx_rd | input | 1 | MAC consumes transmit head word |
| mac_tx_data | output | DW | Transmit head byte |
| mac_tx_eop | output | 1 | Transmit head packet-end tag |
| mac_tx_valid | output | 1 | Transmit FIFO not empty |
| mac_tx_err | input | 1 | MAC reports transmit halted on error |
| tx_stat_rd | input | 1 | Host reads transmit error status |
| tx_stat_err | output | 1 | Transmit error status |
| mac_rx_wr | input | 1 | MAC write into receive FIFO |
| mac_rx_data | input | DW | Received byte |
| mac_rx_eop | input | 1 | Received byte ends packet |
| mac_rx_bad | input | 1 | Packet ends in error; byte not stored |
| rx_rd | input | 1 | Host consumes receive head word |
| rx_rdata | output | DW | Receive head byte |
| rx_reop | output | 1 | Receive head packet-end tag |
| rx_valid | output | 1 | Receive FIFO not empty |
| rxrdy | output | 1 | Receive data, packet, header or discard ready |
| rxfail | output | 1 | A receive packet was discarded |
| rx_stat_rd | input | 1 | Host acknowledges discard |

## Verification
A corrupted pointer or a wrong level shows up in the first cycle afterwards, on either the ready flags or the head word.

| Internal fault | Where it shows at the ports | When |
|---|---|---|
| Pointer or level wrong | Ready flag flips at the wrong fill, or head word does not match the scoreboard | First cycle after the fault |
| Packet count too high | `rxrdy` stays up on an empty FIFO | Right after the last packet-end byte is read |
| Packet count too low | `rxrdy` drops early | Right after the last packet-end byte is read |
| Rollback too far | Earlier good packet vanishes from the data the host reads next | At the following reads |
| Rollback too short | Stale bytes of the discarded packet appear in the data the host reads next | At the following reads |
| Error flags mishandled | Wrong `txrdy` or `rxfail` | The cycle after the status read strobe |

// File: rtl/pkt_fifo_flags.sv
module pkt_fifo_flags #(
  parameter int DW          = 8,
  parameter int DEPTH       = 32,
  parameter int HDR_DEFAULT = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_addr,
  input  logic [$clog2(DEPTH):0]       cfg_wdata,
  input  logic                         tx_wr,
  input  logic [DW-1:0]                tx_wdata,
  input  logic                         tx_weop,
  output logic                         txrdy,
  input  logic                         mac_tx_rd,
  output logic [DW-1:0]                mac_tx_data,
  output logic                         mac_tx_eop,
  output logic                         mac_tx_valid,
  input  logic                         mac_tx_err,
  input  logic                         tx_stat_rd,
  output logic                         tx_stat_err,
  input  logic                         mac_rx_wr,
  input  logic [DW-1:0]                mac_rx_data,
  input  logic                         mac_rx_eop,
  input  logic                         mac_rx_bad,
  input  logic                         rx_rd,
  output logic [DW-1:0]                rx_rdata,
  output logic                         rx_reop,
  output logic                         rx_valid,
  output logic                         rxrdy,
  output logic                         rxfail,
  input  logic                         rx_stat_rd
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int LW = CW + 8;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] tx_thr, rx_thr, hdr_len;
  logic          hdr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr  <= CW'(DEPTH / 2);
      rx_thr  <= CW'(DEPTH / 2);
      hdr_len <= CW'(HDR_DEFAULT);
      hdr_en  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: tx_thr  <= cfg_wdata;
        2'd1: rx_thr  <= cfg_wdata;
        2'd2: hdr_len <= cfg_wdata;
        default: hdr_en <= cfg_wdata[0];
      endcase
    end
  end

  // transmit FIFO
  logic [DW:0]   tx_mem [DEPTH];
  logic [CW-1:0] tx_wp, tx_rp, tx_lvl;
  logic          tx_push, tx_pop, tx_err;

  assign tx_lvl  = tx_wp - tx_rp;
  assign tx_push = tx_wr && (tx_lvl != FULL);
  assign tx_pop  = mac_tx_rd && (tx_lvl != '0);

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= {tx_weop, tx_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_err <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (mac_tx_err)      tx_err <= 1'b1;
      else if (tx_stat_rd) tx_err <= 1'b0;
    end
  end

  assign {mac_tx_eop, mac_tx_data} = tx_mem[tx_rp[AW-1:0]];
  assign mac_tx_valid = (tx_lvl != '0);
  assign tx_stat_err  = tx_err;
  assign txrdy        = !tx_err && ((FULL - tx_lvl) >= tx_thr);

  // receive FIFO
  logic [DW:0]   rx_mem [DEPTH];
  logic [CW-1:0] rx_wp, rx_rp, rx_lvl, rx_lvl_ap, rx_drop, rx_pkts;
  logic [LW-1:0] cur_len;
  logic          cur_ovf, rx_full, rx_discard, rx_push, rx_pop, rx_fail_q;
  logic          head_eop, pkt_in, pkt_out, hdr_hit;

  assign rx_lvl     = rx_wp - rx_rp;
  assign rx_full    = (rx_lvl == FULL);
  assign rx_discard = mac_rx_wr && (mac_rx_bad || (mac_rx_eop && (cur_ovf || rx_full)));
  assign rx_push    = mac_rx_wr && !rx_discard && !rx_full;
  assign rx_pop     = rx_rd && (rx_lvl != '0);
  assign head_eop   = rx_mem[rx_rp[AW-1:0]][DW];
  assign pkt_in     = rx_push && mac_rx_eop;
  assign pkt_out    = rx_pop && head_eop;
  assign rx_lvl_ap  = rx_lvl - {{AW{1'b0}}, rx_pop};
  assign rx_drop    = (cur_len >= {{(LW-CW){1'b0}}, rx_lvl_ap}) ? rx_lvl_ap : cur_len[CW-1:0];
  assign hdr_hit    = hdr_en && (cur_len >= {{(LW-CW){1'b0}}, hdr_len});

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp[AW-1:0]] <= {mac_rx_eop, mac_rx_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp     <= '0;
      rx_rp     <= '0;
      rx_pkts   <= '0;
      cur_len   <= '0;
      cur_ovf   <= 1'b0;
      rx_fail_q <= 1'b0;
    end else begin
      if (rx_discard)   rx_wp <= rx_wp - rx_drop;
      else if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      rx_pkts <= rx_pkts + {{AW{1'b0}}, pkt_in} - {{AW{1'b0}}, pkt_out};
      if (rx_discard || pkt_in)        cur_len <= '0;
      else if (rx_push && cur_len != '1) cur_len <= cur_len + 1'b1;
      if (mac_rx_wr && (mac_rx_eop || mac_rx_bad)) cur_ovf <= 1'b0;
      else if (mac_rx_wr && rx_full)               cur_ovf <= 1'b1;
      if (rx_discard)      rx_fail_q <= 1'b1;
      else if (rx_stat_rd) rx_fail_q <= 1'b0;
    end
  end

  assign {rx_reop, rx_rdata} = rx_mem[rx_rp[AW-1:0]];
  assign rx_valid = (rx_lvl != '0);
  assign rxfail   = rx_fail_q;
  assign rxrdy    = (rx_lvl >= rx_thr) || (rx_pkts != '0) || hdr_hit || rx_fail_q;

  assert_tx_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl <= FULL);
  assert_rx_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= FULL);
  assert_pkts_fit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pkts <= rx_lvl);
  assert_err_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stat_err |-> !txrdy);
  assert_err_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !tx_stat_rd) |=> tx_err);
  assert_fail_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rxfail |-> rxrdy);
  assert_fail_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxfail && !rx_stat_rd) |=> rxfail);
endmodule

// File: tb/sim_pkt_fifo_flags.sv
module sim_pkt_fifo_flags;
  localparam int D = 32;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [5:0] cfg_wdata = 0;
  logic tx_wr = 0, tx_weop = 0, mac_tx_rd = 0, mac_tx_err = 0, tx_stat_rd = 0;
  logic [7:0] tx_wdata = 0, mac_rx_data = 0;
  logic mac_rx_wr = 0, mac_rx_eop = 0, mac_rx_bad = 0, rx_rd = 0, rx_stat_rd = 0;
  logic txrdy, mac_tx_eop, mac_tx_valid, tx_stat_err, rx_reop, rx_valid, rxrdy, rxfail;
  logic [7:0] mac_tx_data, rx_rdata;

  pkt_fifo_flags u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] txq[$], rxq[$];
  int pend = 0, curlen = 0, tthr = 16, rthr = 16, hlen = 14;
  bit hen = 0, terr = 0, rfail = 0, rovf = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rx_pkts_model();
    int n = 0;
    foreach (rxq[i]) if (rxq[i][8]) n++;
    return n;
  endfunction

  task automatic chk_tx(input string req);
    chk(req, txrdy, int'(!terr && (D - txq.size() >= tthr)));
  endtask

  task automatic chk_rx(input string req);
    chk(req, rxrdy, int'(rxq.size() >= rthr || rx_pkts_model() > 0 ||
                         (hen && curlen >= hlen) || rfail));
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic cfg(input int a, input int v);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 6'(v);
    step; cfg_we = 0;
    case (a) 0: tthr = v; 1: rthr = v; 2: hlen = v; default: hen = v[0]; endcase
  endtask

  task automatic tx_put(input logic [7:0] d, input bit e);
    tx_wr = 1; tx_wdata = d; tx_weop = e;
    if (txq.size() < D) txq.push_back({e, d});
    step; tx_wr = 0;
  endtask

  task automatic tx_take(input string req);
    chk({req, " valid"}, mac_tx_valid, 1);
    chk({req, " data"}, {mac_tx_eop, mac_tx_data}, txq[0]);
    void'(txq.pop_front());
    mac_tx_rd = 1; step; mac_tx_rd = 0;
  endtask

  task automatic model_discard;
    repeat (pend) void'(rxq.pop_back());
    pend = 0; curlen = 0; rovf = 0; rfail = 1;
  endtask

  task automatic rx_put(input logic [7:0] d, input bit e, input bit bad);
    mac_rx_wr = 1; mac_rx_data = d; mac_rx_eop = e; mac_rx_bad = bad;
    if (bad || (e && (rovf || rxq.size() == D))) model_discard;
    else if (rxq.size() == D) rovf = 1;
    else begin
      rxq.push_back({e, d});
      if (e) begin pend = 0; curlen = 0; end
      else begin pend++; curlen++; end
    end
    step; mac_rx_wr = 0; mac_rx_bad = 0; mac_rx_eop = 0;
  endtask

  task automatic rx_take(input string req);
    chk({req, " valid"}, rx_valid, 1);
    chk({req, " data"}, {rx_reop, rx_rdata}, rxq[0]);
    if (rxq.size() <= pend) pend--;
    void'(rxq.pop_front());
    rx_rd = 1; step; rx_rd = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step;
    // R1 reset state
    chk("R1 txrdy", txrdy, 1); chk("R1 rxrdy", rxrdy, 0); chk("R1 rxfail", rxfail, 0);
    chk("R1 txerr", tx_stat_err, 0); chk("R1 txvalid", mac_tx_valid, 0);
    chk("R1 rxvalid", rx_valid, 0);

    // R2 default threshold boundary, R4 order
    for (int i = 0; i < 17; i++) begin
      tx_put(8'(i * 7 + 1), (i % 5) == 4);
      chk_tx("R2 fill");
    end
    chk("R2 below thr", txrdy, 0);
    while (txq.size() > 0) begin tx_take("R4 tx"); chk_tx("R2 drain"); end

    // R10 tx threshold, R9 full and empty
    cfg(0, 4);
    for (int i = 0; i < 33; i++) begin tx_put(8'(200 - i), i == 31); chk_tx("R10 thr4"); end
    chk("R9 tx full no rdy", txrdy, 0);
    while (txq.size() > 0) tx_take("R9 tx full order");
    mac_tx_rd = 1; step; mac_tx_rd = 0;
    chk("R9 tx empty read", mac_tx_valid, 0);
    tx_put(8'h5a, 1); tx_take("R9 after empty read");

    // R3 error blocking and read-to-clear
    mac_tx_err = 1; terr = 1; step; mac_tx_err = 0;
    chk_tx("R3 err blocks");
    repeat (5) step;
    chk("R3 err held", txrdy, 0);
    tx_stat_rd = 1; #1;
    chk("R3 status during read", tx_stat_err, 1);
    step; tx_stat_rd = 0; terr = 0;
    chk("R3 status cleared", tx_stat_err, 0);
    chk_tx("R3 rdy back");
    mac_tx_err = 1; tx_stat_rd = 1; terr = 1; step; mac_tx_err = 0; tx_stat_rd = 0;
    chk("R3 set wins", tx_stat_err, 1);
    tx_stat_rd = 1; step; tx_stat_rd = 0; terr = 0;

    // R5 receive threshold
    for (int i = 0; i < 16; i++) begin
      rx_put(8'(i + 3), 0, 0);
      chk_rx(i == 15 ? "R5 at thr" : "R5 below thr");
    end
    chk("R5 rdy", rxrdy, 1);
    for (int i = 0; i < 10; i++) begin rx_take("R4 rx"); chk_rx("R5 drain"); end
    // R6 packet end below threshold
    rx_put(8'h99, 1, 0);
    chk("R6 pkt end", rxrdy, 1);
    while (rxq.size() > 0) begin rx_take("R4 rx pkt"); chk_rx("R6 drain"); end
    chk("R6 empty", rxrdy, 0);
    rx_put(8'h11, 0, 0); rx_put(8'h12, 0, 0);
    chk_rx("R6 partial");
    rx_put(8'h13, 1, 0);
    chk("R6 short pkt", rxrdy, 1);
    while (rxq.size() > 0) rx_take("R6 short data");

    // R7 header option
    for (int i = 0; i < 14; i++) rx_put(8'(i), 0, 0);
    chk("R7 header off", rxrdy, 0);
    cfg(3, 1);
    chk("R7 header on", rxrdy, 1);
    // R8 bad end discards in-progress packet
    rx_put(8'hee, 1, 1);
    chk("R8 rxfail", rxfail, 1); chk("R8 rxrdy", rxrdy, 1);
    chk("R8 emptied", rx_valid, 0);
    rx_stat_rd = 1; step; rx_stat_rd = 0; rfail = 0;
    chk("R8 ack", rxfail, 0); chk_rx("R8 ack rdy");
    cfg(2, 4);
    for (int i = 0; i < 4; i++) begin rx_put(8'(i + 40), 0, 0); chk_rx("R7 hdr len 4"); end
    chk("R7 hdr len hit", rxrdy, 1);
    rx_put(8'h44, 1, 0);
    while (rxq.size() > 0) rx_take("R7 data");
    cfg(3, 0);

    // R8 earlier packet kept, partly read packet trimmed
    rx_put(8'ha1, 0, 0); rx_put(8'ha2, 1, 0);
    rx_put(8'hb1, 0, 0); rx_put(8'hb2, 0, 0); rx_put(8'hb3, 0, 0);
    rx_take("R8 keep A"); rx_take("R8 keep A");
    rx_take("R8 read B");
    rx_put(8'h00, 0, 1);
    chk("R8 fail2", rxfail, 1);
    chk("R8 only unread removed", rx_valid, 0);
    rx_stat_rd = 1; step; rx_stat_rd = 0; rfail = 0;

    // R9 overflow then packet end discards
    for (int i = 0; i < 33; i++) rx_put(8'(i + 100), 0, 0);
    chk("R9 rx full rdy", rxrdy, 1);
    rx_put(8'h77, 1, 0);
    chk("R9 ovf fail", rxfail, 1);
    chk("R9 ovf dropped", rx_valid, 0);
    rx_rd = 1; step; rx_rd = 0;
    chk("R9 rx empty read", rx_valid, 0);
    rx_stat_rd = 1; step; rx_stat_rd = 0; rfail = 0;
    chk_rx("R9 idle");
    rx_put(8'h31, 1, 0); rx_take("R9 after ovf");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule